// File: doc/BRIEF.md
# Flash Completion Polling Controller

This block runs on the host side of a parallel flash device. After software has launched a program or erase operation on the flash, it starts the controller with the operation kind, the byte it expects to find at the target, the target address and a poll budget. From then on the controller reads that address over and over through a request/acknowledge read port. It decides from the returned data alone whether the flash is still busy. No status register is used.

Two detection methods are available. The data-bit method watches the top data bit: while a program is in progress that bit reads as the inverse of the expected byte's top bit, and while an erase is in progress it reads as 0. The toggle method watches the bit just below the top. While the device is working, that bit flips between consecutive reads. Once the device is seen as settled, the controller makes one more read and reports that byte as the true stored value. A poll budget can end the wait early with an error flag.

Top module: `fpoll_ctrl`

## Requirements
- R1: After reset `busy_o`, `rd_req_o`, `done_o` and `timeout_o` are 0 and `result_o` is all zeros.
- R2: `start_i` is accepted only while `busy_o` is 0, and it latches mode, expected byte, address and budget. A `start_i` while `busy_o` is 1 is ignored: the address on the read port, the number of reads and the reported result of the running operation stay as they would have been.
- R3: `rd_req_o` stays high with `rd_addr_o` stable (equal to the latched address) until `rd_ack_i` is sampled high. Each clock edge with both high completes exactly one read, and `rd_data_i` is taken at that edge.
- R4: Data-bit method (`method_i`=0) with a program operation (`erase_i`=0): the device counts as busy while `rd_data_i[7]` differs from bit 7 of the expected byte.
- R5: Data-bit method with an erase operation (`erase_i`=1): the device counts as busy while `rd_data_i[7]` is 0.
- R6: Toggle method (`method_i`=1): the device counts as busy while `rd_data_i[6]` differs from bit 6 of the previous read of the same operation. The first read of an operation never counts as settled, so at least two status reads are made.
- R7: After a settled status read, the controller makes exactly one further read. On the clock edge that completes it, `result_o` takes that read's data, and on the same edge `done_o` pulses for one cycle with `timeout_o` at 0.
- R8: With `max_polls_i` nonzero, if `max_polls_i` status reads are made and none of them is settled, `done_o` and `timeout_o` pulse together for one cycle. In that case `result_o` holds the last status read, and no extra read is made. A settled read that is also the last allowed poll counts as completion.
- R9: `max_polls_i` = 0 disables the budget, so polling continues until the device settles.
- R10: `busy_o` is 1 from the cycle after an accepted start until the cycle in which `done_o` pulses, where it is already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start polling (accepted when idle) |
| method_i | input | 1 | 0 = data-bit method, 1 = toggle method |
| erase_i | input | 1 | 0 = program operation, 1 = erase operation |
| exp_data_i | input | DW | Byte expected after a program |
| addr_i | input | AW | Address to poll |
| max_polls_i | input | CW | Status read budget, 0 = unlimited |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Budget ran out (valid with done_o) |
| result_o | output | DW | Final byte read |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DW | Read data |

## Verification
A modelled device answers reads with a busy status byte for a chosen number of reads and then returns the true byte. Each scenario targets a different rule:
- Program and erase runs with the data-bit method, with both polarities of the expected top bit, show that the comparison follows the operation kind.
- Toggle runs use busy lengths whose parity either does or does not line up with bit 6 of the true byte. This separates genuine toggle comparison from counting reads, and a zero busy length shows that two status reads are the minimum.
- Budget runs cover a hit on the limit, completion on exactly the last allowed poll, a one-poll toggle budget and an unlimited long run.
- Variable acknowledge latency and a stray start in mid-operation exercise the handshake and the start-ignore rule.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_FINAL = 2'd2
    } fsm_e;

    typedef enum logic {
        MTH_DATABIT = 1'b0,
        MTH_TOGGLE  = 1'b1
    } method_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_e;

    typedef struct packed {
        method_e method;
        op_e     op;
    } mode_t;

    // Data-bit rule: erase settles when the top bit reads 1,
    // program settles when the top bit matches the expected byte.
    function automatic logic databit_settled(op_e op, logic rd_bit, logic exp_bit);
        return (op == OP_ERASE) ? rd_bit : (rd_bit == exp_bit);
    endfunction

    // Toggle rule: settled when a prior sample exists and bit did not move.
    function automatic logic toggle_settled(logic have_prev, logic prev_bit, logic rd_bit);
        return have_prev && (prev_bit == rd_bit);
    endfunction

endpackage

// File: rtl/fpoll_judge.sv
module fpoll_judge
    import fpoll_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          sample,
    input  mode_t         mode,
    input  logic          exp_top,
    input  logic [DW-1:0] rd_data,
    output logic          settled
);
    localparam int TOP_BIT = DW - 1;
    localparam int TOG_BIT = DW - 2;

    logic have_prev_q;
    logic prev_tog_q;
    logic [1:0] seen_q;

    always_comb begin
        if (mode.method == MTH_TOGGLE)
            settled = toggle_settled(have_prev_q, prev_tog_q, rd_data[TOG_BIT]);
        else
            settled = databit_settled(mode.op, rd_data[TOP_BIT], exp_top);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_prev_q <= 1'b0;
            prev_tog_q  <= 1'b0;
            seen_q      <= 2'd0;
        end else if (sample) begin
            have_prev_q <= 1'b1;
            prev_tog_q  <= rd_data[TOG_BIT];
            if (seen_q != 2'd3)
                seen_q <= seen_q + 2'd1;
        end
    end

    // R6: toggle mode never settles on the first status read.
    assert_toggle_two_reads_R6: assert property (@(posedge clk) disable iff (rst)
        (sample && settled && mode.method == MTH_TOGGLE) |-> (seen_q != 2'd0));

endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [CW-1:0] limit,
    input  logic          step,
    output logic          last
);
    logic [CW-1:0] lim_q;
    logic [CW-1:0] cnt_q;

    assign last = (lim_q != '0) && (cnt_q == lim_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            lim_q <= limit;
            cnt_q <= '0;
        end else if (step && !last && cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: with a nonzero budget the used count never reaches the limit.
    assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
        (lim_q != '0) |-> (cnt_q < lim_q));

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
    import fpoll_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          method_i,
    input  logic          erase_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] max_polls_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [DW-1:0] result_o,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i
);
    localparam int TOP_BIT = DW - 1;

    fsm_e          st_q;
    mode_t         mode_q;
    logic          exp_top_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] res_q;
    logic          done_q;
    logic          tmo_q;

    logic accept;
    logic xfer;
    logic poll_xfer;
    logic settled;
    logic last_poll;

    assign accept    = start_i && (st_q == ST_IDLE);
    assign xfer      = rd_req_o && rd_ack_i;
    assign poll_xfer = xfer && (st_q == ST_POLL);

    assign busy_o    = (st_q != ST_IDLE);
    assign rd_req_o  = (st_q == ST_POLL) || (st_q == ST_FINAL);
    assign rd_addr_o = addr_q;
    assign done_o    = done_q;
    assign timeout_o = tmo_q;
    assign result_o  = res_q;

    fpoll_judge #(.DW(DW)) judge_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .sample  (poll_xfer),
        .mode    (mode_q),
        .exp_top (exp_top_q),
        .rd_data (rd_data_i),
        .settled (settled)
    );

    fpoll_budget #(.CW(CW)) budget_i (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .limit (max_polls_i),
        .step  (poll_xfer && !settled),
        .last  (last_poll)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            mode_q    <= '{method: MTH_DATABIT, op: OP_PROGRAM};
            exp_top_q <= 1'b0;
            addr_q    <= '0;
            res_q     <= '0;
            done_q    <= 1'b0;
            tmo_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q    <= '{method: method_e'(method_i), op: op_e'(erase_i)};
                        exp_top_q <= exp_data_i[TOP_BIT];
                        addr_q    <= addr_i;
                        st_q      <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    if (xfer) begin
                        if (settled) begin
                            st_q <= ST_FINAL;
                        end else if (last_poll) begin
                            st_q   <= ST_IDLE;
                            res_q  <= rd_data_i;
                            done_q <= 1'b1;
                            tmo_q  <= 1'b1;
                        end
                    end
                end
                ST_FINAL: begin
                    if (xfer) begin
                        st_q   <= ST_IDLE;
                        res_q  <= rd_data_i;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);
    assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));
    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);
    assert_busy_addr_kept_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(rd_addr_o));
    assert_tmo_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> done_o);
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: tb/fpoll_ctrl_tb_top.sv
module fpoll_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int CW = 16;

    typedef struct packed {
        logic        tmo;
        logic [7:0]  res;
        logic [15:0] reads;
        logic [7:0]  tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, method_i = 1'b0, erase_i = 1'b0;
    logic [DW-1:0] exp_data_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] max_polls_i = '0;
    logic busy_o, done_o, timeout_o, rd_req_o, rd_ack_i;
    logic [DW-1:0] result_o, rd_data_i;
    logic [AW-1:0] rd_addr_o;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    exp_t sb_q[$];

    // device model state
    int         rd_idx = 0;
    int         dev_busy = 0;
    logic [7:0] dev_true = '0;
    logic       dev_erase = 1'b0;
    logic       dev_exp7 = 1'b0;
    logic [AW-1:0] dev_addr = '0;
    int         lat = 0;

    always #5 clk = ~clk;

    fpoll_ctrl #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .method_i(method_i),
        .erase_i(erase_i), .exp_data_i(exp_data_i), .addr_i(addr_i),
        .max_polls_i(max_polls_i), .busy_o(busy_o), .done_o(done_o),
        .timeout_o(timeout_o), .result_o(result_o), .rd_req_o(rd_req_o),
        .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i)
    );

    function automatic logic [7:0] dev_read(int i, int b, logic er, logic e7, logic [7:0] tv);
        logic par;
        par = i[0];
        if (i <= b) return {(er ? 1'b0 : ~e7), par, 6'h15};
        return tv;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Device responder: answers requests after lat idle cycles.
    initial begin
        int w;
        w = 0;
        rd_ack_i = 1'b0;
        rd_data_i = '0;
        forever begin
            @(negedge clk);
            if (rd_req_o && !rst) begin
                if (w >= lat) begin
                    rd_idx++;
                    rd_ack_i  = 1'b1;
                    rd_data_i = dev_read(rd_idx, dev_busy, dev_erase, dev_exp7, dev_true);
                    check("R3 read address", rd_addr_o, dev_addr);
                    w = 0;
                end else begin
                    rd_ack_i = 1'b0;
                    w++;
                end
            end else begin
                rd_ack_i = 1'b0;
                w = 0;
            end
        end
    end

    // Monitor: compares each completion against the scoreboard.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (done_o && !rst) begin
                if (sb_q.size() == 0) begin
                    check("R7 unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    check($sformatf("R8 timeout flag case %0d", e.tag), timeout_o, e.tmo);
                    check($sformatf("R7 result case %0d", e.tag), result_o, e.res);
                    check($sformatf("R6 read count case %0d", e.tag), rd_idx, e.reads);
                    check($sformatf("R10 busy at done case %0d", e.tag), busy_o, 0);
                end
                done_cnt++;
            end
        end
    end

    task automatic run_op(int tag, logic meth, logic er, logic [7:0] ex, logic [7:0] tv,
                          int b, int mx, int l, logic stray);
        exp_t e;
        logic prev6;
        int target;
        e = '0;
        e.tag = tag[7:0];
        for (int i = 1; i < 2000; i++) begin
            logic [7:0] d;
            logic ok;
            d = dev_read(i, b, er, ex[7], tv);
            if (meth) ok = (i > 1) && (d[6] == prev6);
            else      ok = er ? d[7] : (d[7] == ex[7]);
            prev6 = d[6];
            if (ok) begin
                e.tmo = 1'b0; e.res = dev_read(i + 1, b, er, ex[7], tv); e.reads = 16'(i + 1);
                break;
            end
            if (mx != 0 && i == mx) begin
                e.tmo = 1'b1; e.res = d; e.reads = 16'(i);
                break;
            end
        end
        sb_q.push_back(e);
        @(negedge clk);
        rd_idx = 0; dev_busy = b; dev_true = tv; dev_erase = er; dev_exp7 = ex[7];
        dev_addr = 16'h1000 + 16'(tag); lat = l;
        method_i = meth; erase_i = er; exp_data_i = ex; addr_i = dev_addr;
        max_polls_i = CW'(mx);
        target = done_cnt + 1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R10 busy after start", busy_o, 1);
        if (stray) begin
            repeat (3) @(negedge clk);
            addr_i = 16'hBEEF; max_polls_i = 1; method_i = ~meth;
            start_i = 1'b1;   // R2: ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        wait (done_cnt == target);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 busy", busy_o, 0);
        check("R1 req", rd_req_o, 0);
        check("R1 done", done_o, 0);
        check("R1 timeout", timeout_o, 0);
        check("R1 result", result_o, 0);
        run_op(1,  0, 0, 8'hA5, 8'hA5, 3, 0, 0, 0);   // R4 top bit 1
        run_op(2,  0, 0, 8'h3C, 8'h3C, 4, 0, 2, 0);   // R4 top bit 0
        run_op(3,  0, 0, 8'h81, 8'h81, 0, 8, 1, 0);   // R4 immediately settled
        run_op(4,  0, 1, 8'h00, 8'hFF, 5, 0, 1, 0);   // R5 erase
        run_op(5,  1, 0, 8'h5A, 8'h5A, 4, 0, 0, 0);   // R6 no coincidence
        run_op(6,  1, 0, 8'h5A, 8'h5A, 3, 0, 1, 0);   // R6 parity coincidence
        run_op(7,  1, 0, 8'h5A, 8'h5A, 0, 0, 0, 0);   // R6 two-read minimum
        run_op(8,  0, 0, 8'hA5, 8'hA5, 5, 3, 0, 0);   // R8 budget hit
        run_op(9,  1, 1, 8'h00, 8'hFF, 4, 1, 0, 0);   // R8 one-poll toggle
        run_op(10, 0, 1, 8'h00, 8'hFF, 40, 0, 0, 0);  // R9 unlimited
        run_op(11, 0, 0, 8'hA5, 8'hA5, 2, 3, 0, 0);   // R8 settle on last poll
        run_op(12, 0, 0, 8'hA5, 8'hA5, 6, 0, 3, 1);   // R2 stray start
        check("R2 idle after stray run", busy_o, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule